// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a 512 x 8 memory array. The array is a register model that stands in for nonvolatile storage. A fast system clock samples SCL and SDA through synchronizers. The block finds start and stop conditions and shifts bytes in on SCL rising edges. It acknowledges by pulling SDA low through an open-drain enable. The memory image, the address pointer and the busy timer all live inside the block.

A master writes a word address, which loads a 9-bit pointer. Data bytes that follow are collected into a 16-byte page buffer. The buffer is committed to the array at the stop condition, and the block then goes busy for a fixed number of system clocks. Reads come from the same pointer, either through a random read with a repeated start or through a current-address read. A read continues byte after byte while the master keeps acknowledging. A write-protect input stops any commit from reaching the array.

Top module: `twowire_eeprom`

## Requirements
- R1: The address byte, MSB first, carries 1010 in bits 7..4, the A2 strap in bit 3, the A1 strap in bit 2, a page bit P0 in bit 1 and the direction in bit 0 (1 = read). The block pulls SDA low in the 9th clock only when bits 7..2 match and the block is not busy. On any other address it gives no acknowledge and ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Clock pulses after a stop and before a new start get no acknowledge.
- R3: In a write, the word address byte loads the pointer as {P0, word}. Each later data byte is acknowledged and buffered at the pointer. After each data byte only pointer bits 3..0 advance, so the write wraps inside its 16-byte page and bits 8..4 stay fixed.
- R4: Buffered bytes reach the array at the stop condition. After that the block stays busy for BUSY_CLKS system clocks and acknowledges no address byte. A write that ends before any data byte starts no busy period.
- R5: A repeated start after the word address, followed by a read address byte, returns the byte at the newly loaded pointer.
- R6: During reads the pointer advances by one after each byte, across the whole array, with 511 followed by 0. Reading goes on while the master acknowledges. After a master no-acknowledge and a stop, SDA is released.
- R7: A current-address read ignores P0 and returns the byte at the pointer. After a write the pointer is the next location in the written page. After a read it is the next array location.
- R8: Data bytes go out MSB first. The block changes its SDA drive only while SCL is low.
- R9: While WP is high, write bytes are still acknowledged, but the array is unchanged and no busy period follows.
- R10: After reset SDA is released, every array byte reads 8'hFF and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain drive) |
| strap_a2_i | input | 1 | Device address strap compared with address bit 3 |
| strap_a1_i | input | 1 | Device address strap compared with address bit 2 |
| wp_i | input | 1 | Write protect, 1 blocks array updates |

## Verification
A wrong address decode shows up at once as a missing or extra low level in the 9th clock of the address byte. A pointer that steps the wrong way, or leaves its page during a write, hides until a later read. It then appears as a wrong byte in a current-address or sequential read, often several transactions later. The sweeps therefore read back every page that was written, and cross the array end. A bad busy timer or protect gate is seen on the very next address byte, as a wrong acknowledge.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int BUSY_CLKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic strap_a2_i,
  input  logic strap_a1_i,
  input  logic wp_i
);
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 4;
  localparam int PAGE  = 1 << PW;
  localparam int BW    = $clog2(BUSY_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD} st_t;

  st_t              st;
  logic [2:0]       scl_p, sda_p;
  logic [3:0]       bitcnt;
  logic             ninth;
  logic [7:0]       sr;
  logic [6:0]       rbyte;
  logic [AW-1:0]    ptr;
  logic             p0;
  logic [PAGE-1:0]  vmask;
  logic [7:0]       pbuf [PAGE];
  logic [7:0]       mem  [DEPTH];
  logic [BW-1:0]    busy_cnt;
  logic             oe;

  logic scl_rise, scl_fall, start_c, stop_c, busy, dev_hit;
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  assign busy     = busy_cnt != '0;
  assign dev_hit  = sr[7:4] == 4'b1010 && sr[3] == strap_a2_i && sr[2] == strap_a1_i;
  assign sda_oe_o = oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p    <= 3'b111;
      sda_p    <= 3'b111;
      st       <= S_IDLE;
      bitcnt   <= '0;
      ninth    <= 1'b0;
      sr       <= '0;
      rbyte    <= '0;
      ptr      <= '0;
      p0       <= 1'b0;
      vmask    <= '0;
      busy_cnt <= '0;
      oe       <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (start_c) begin
        st     <= S_DEV;
        bitcnt <= '0;
        ninth  <= 1'b0;
        oe     <= 1'b0;
        vmask  <= '0;
      end else if (stop_c) begin
        st    <= S_IDLE;
        ninth <= 1'b0;
        oe    <= 1'b0;
        vmask <= '0;
        if (|vmask && !wp_i) begin
          for (int i = 0; i < PAGE; i++)
            if (vmask[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
          busy_cnt <= BW'(BUSY_CLKS);
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            sr     <= {sr[6:0], sda_p[1]};
            bitcnt <= bitcnt + 4'd1;
          end else begin
            ninth <= 1'b1;
            if (st == S_RD && sda_p[1]) st <= S_IDLE;
          end
        end
        if (scl_fall) begin
          if (ninth) begin
            ninth  <= 1'b0;
            bitcnt <= '0;
            oe     <= 1'b0;
            if (st == S_RD) begin
              oe    <= ~mem[ptr][7];
              rbyte <= mem[ptr][6:0];
            end
          end else if (bitcnt == 4'd8) begin
            case (st)
              S_DEV: begin
                if (dev_hit && !busy) begin
                  oe <= 1'b1;
                  st <= sr[0] ? S_RD : S_WA;
                  if (!sr[0]) p0 <= sr[1];
                end else begin
                  st <= S_IDLE;
                end
              end
              S_WA: begin
                oe  <= 1'b1;
                ptr <= {p0, sr};
                st  <= S_WD;
              end
              S_WD: begin
                oe                    <= 1'b1;
                pbuf[ptr[PW-1:0]]     <= sr;
                vmask[ptr[PW-1:0]]    <= 1'b1;
                ptr[PW-1:0]           <= ptr[PW-1:0] + PW'(1);
              end
              S_RD: begin
                oe  <= 1'b0;
                ptr <= ptr + AW'(1);
              end
              default: ;
            endcase
          end else if (st == S_RD && bitcnt != 4'd0) begin
            oe    <= ~rbyte[6];
            rbyte <= {rbyte[5:0], 1'b0};
          end
        end
      end
    end
  end

  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_p[2]);

  p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o);

  p_protect_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WD && $past(st) == S_WD) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

  p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) == S_RD && ptr != $past(ptr)) |-> ptr == AW'($past(ptr) + 1));
endmodule

// File: tb/twowire_eeprom_bench.sv
module twowire_eeprom_bench;
  localparam int Q    = 4;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, msda, wp;
  logic sda_oe, sda_bus;
  assign sda_bus = msda & ~sda_oe;

  twowire_eeprom #(.BUSY_CLKS(BUSY)) u_twowire_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_a2_i(1'b1), .strap_a1_i(1'b0), .wp_i(wp));

  logic [7:0] model [512];
  logic [8:0] mptr;
  int tests = 0, fails = 0, glitch = 0;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n && scl && scl_d && sda_oe != oe_d) glitch++;
    scl_d = scl;
    oe_d  = sda_oe;
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic p, input logic rw);
    return {4'b1010, 1'b1, 1'b0, p, rw};
  endfunction

  task automatic bitx(input logic b, output logic r);
    msda = b; w(2*Q); scl = 1'b1; w(Q); r = sda_bus; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bstart;
    msda = 1'b1; w(Q); scl = 1'b1; w(Q); msda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bstop;
    msda = 1'b0; w(Q); scl = 1'b1; w(Q); msda = 1'b1; w(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(d[i], r);
    bitx(1'b1, r);
    ack = !r;
  endtask

  task automatic rdbyte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, r); d[i] = r; end
    bitx(last, r);
  endtask

  task automatic set_ptr(input logic [8:0] a);
    logic k;
    bstart; wbyte(dev(a[8], 1'b0), k); wbyte(a[7:0], k);
  endtask

  task automatic page_wr(input logic [4:0] pg, input logic [3:0] off, input int n, input logic prot);
    logic k; logic [7:0] d;
    bstart;
    wbyte(dev(pg[4], 1'b0), k); chk(k, "R3 write address ack", k, 1);
    wbyte({pg[3:0], off}, k);   chk(k, "R3 word address ack", k, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(pg * 37 + i * 11 + 3);
      wbyte(d, k); chk(k, "R3 data ack", k, 1);
      if (!prot) model[{pg, 4'(off + i)}] = d;
    end
    bstop;
    mptr = {pg, 4'(off + n)};
  endtask

  task automatic readback(input logic [4:0] pg, input string tag);
    logic k; logic [7:0] d;
    set_ptr({pg, 4'h0});
    bstart; wbyte(dev(1'b0, 1'b1), k);
    for (int i = 0; i < 16; i++) begin
      rdbyte(i == 15, d);
      chk(d == model[{pg, 4'(i)}], tag, d, model[{pg, 4'(i)}]);
    end
    bstop;
    mptr = 9'({pg, 4'h0} + 16);
  endtask

  initial begin
    logic k; logic [7:0] d; logic [6:0] a7; logic [8:0] ad;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1; wp = 1'b0;
    w(5); rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0, "R10 SDA released", sda_oe, 0);

    bstart; wbyte(dev(1'b1, 1'b1), k); chk(k, "R7 read address ack", k, 1);
    rdbyte(1'b1, d); bstop;
    chk(d == 8'hFF, "R10 erased byte at pointer 0", d, 8'hFF);
    mptr = 9'd1;

    for (int v = 0; v < 128; v++) begin
      a7 = 7'(v);
      bstart; wbyte({a7, 1'b0}, k); bstop;
      chk(k == (a7[6:3] == 4'b1010 && a7[2] && !a7[1]), "R1 address match", k,
          (a7[6:3] == 4'b1010 && a7[2] && !a7[1]));
    end

    bstart; wbyte(dev(1'b0, 1'b0), k); bstop;
    wbyte(dev(1'b0, 1'b0), k); chk(!k, "R2 no ack without start", k, 0);
    wbyte(8'h55, k); chk(!k, "R2 no ack after stop", k, 0);

    page_wr(5'd0, 4'd7, 16, 1'b0);
    bstart; wbyte(dev(1'b0, 1'b0), k); bstop;
    chk(!k, "R4 busy no ack", k, 0);
    w(BUSY);
    bstart; wbyte(dev(1'b0, 1'b0), k); bstop;
    chk(k, "R4 ack after busy", k, 1);

    page_wr(5'd18, 4'd12, 20, 1'b0); w(BUSY);
    page_wr(5'd31, 4'd0, 16, 1'b0);  w(BUSY);
    page_wr(5'd9, 4'd3, 5, 1'b0);    w(BUSY);

    bstart; wbyte(dev(~mptr[8], 1'b1), k); rdbyte(1'b1, d); bstop;
    chk(d == model[mptr], "R7 current read after write", d, model[mptr]);
    mptr = mptr + 9'd1;
    bstart; wbyte(dev(~mptr[8], 1'b1), k); rdbyte(1'b1, d); bstop;
    chk(d == model[mptr], "R7 current read after read", d, model[mptr]);

    for (int j = 0; j < 6; j++) begin
      ad = 9'((j * 131 + 7) % 512);
      set_ptr(ad);
      bstart; wbyte(dev(1'b0, 1'b1), k); chk(k, "R5 read address ack", k, 1);
      rdbyte(1'b1, d); bstop;
      chk(d == model[ad], "R5 random read", d, model[ad]);
    end

    set_ptr(9'd500);
    bstart; wbyte(dev(1'b0, 1'b1), k);
    for (int i = 0; i < 30; i++) begin
      rdbyte(i == 29, d);
      chk(d == model[9'(500 + i)], "R6 sequential read", d, model[9'(500 + i)]);
    end
    bstop;
    chk(sda_oe == 1'b0, "R6 release after no-ack", sda_oe, 0);
    bstart; wbyte(dev(1'b1, 1'b1), k); rdbyte(1'b1, d); bstop;
    chk(d == model[9'd18], "R7 pointer after wrap", d, model[9'd18]);

    readback(5'd0,  "R3 page 0 readback");
    readback(5'd18, "R3 page 18 wrap readback");
    readback(5'd31, "R3 page 31 readback");
    readback(5'd9,  "R3 page 9 readback");

    wp = 1'b1;
    page_wr(5'd3, 4'd0, 4, 1'b1);
    bstart; wbyte(dev(1'b0, 1'b0), k); bstop;
    chk(k, "R9 no busy while protected", k, 1);
    wp = 1'b0;
    readback(5'd3, "R9 protected page unchanged");

    chk(glitch == 0, "R8 SDA drive changed with SCL high", glitch, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule